// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management transactions towards external PHYs over a two-wire serial link. Software reaches it through three word registers on a simple single-cycle write port with a combinational read-back mux. It sets a clock divider, writes a command word that holds a PHY address, a register address and a read flag, and moves 16-bit values through a data register. Software then polls a busy flag until the transaction completes.

The management clock is derived from the system clock. Each half-period lasts a programmable number of system cycles. On a read, the master releases the data line for the turnaround and samples the PHY's reply. If the PHY does not claim the line, an error flag is raised. On a write, the master drives the whole frame itself.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy (config bit 31) and the read-error flag (config bit 30) read 0, the divider field (config bits [DIV_W-1:0], address 0) reads DEF_DIV, MDC is low and the MDIO output enable is low.
- R2: A config write with a divider value of at least MIN_DIV replaces the divider. A smaller value is ignored and the old divider stays.
- R3: While a transaction runs, each MDC high phase and each MDC low phase lasts exactly "divider" system cycles. MDC stays low when idle.
- R4: Writing the command register (address 1) with bit 15 set starts a read. The PHY address comes from bits [9:5] and the register address from bits [4:0]. The command register reads back these three fields.
- R5: Writing the data register (address 2) while the stored command's read flag is clear starts a write frame. The frame is 32 ones, then 01, then 01, then the PHY address, the register address, 10, and the 16 data bits, each field MSB first. MDIO changes only on MDC falling edges.
- R6: A read frame carries opcode 10. MDIO output enable is low from the first turnaround bit to the end of the frame.
- R7: Read data is sampled on MDC rising edges, MSB first. It is placed in data register bits [15:0] on the same clock edge that busy clears.
- R8: The read-error flag is set when the second turnaround bit of a read is sampled high. The flag is cleared when any transaction starts.
- R9: Busy stays set for exactly 128 × divider cycles per transaction. Writes to any register while busy is set are ignored.
- R10: A data-register write while the stored command has its read flag set only stores the value and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | 2 | Register select: 0 config/status, 1 command, 2 data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read-back of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (high drives the line) |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The assertions assume the following about the inputs:
- `reg_addr` is stable while `reg_wr` is high.
- The external line resolves to a defined value when nobody drives it, as a pull-up would make it.
- Reset is applied before any register access.

The stimulus respects these. The bench models the line as a pull-up resolved from the master's enable and from a behavioural PHY. That PHY only drives between the turnaround and the end of a read. All register traffic is one-cycle strobes applied on falling clock edges, and nothing is issued before reset is released.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int BUSY_BIT   = 31;
  localparam int ERR_BIT    = 30;
  localparam int CMD_RD_BIT = 15;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == div - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        ta_err
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA1_IDX  = CNT_W'(TA_FIRST);
  localparam logic [CNT_W-1:0] TA2_IDX  = CNT_W'(TA_SECOND);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(DATA_FIRST);
  localparam logic [CNT_W-1:0] PRE_IDX  = CNT_W'(PRE_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bitcnt;
  logic                  rd_q;

  assign frame  = {{PRE_BITS{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad,
                   2'b10, (is_rd ? 16'h0000 : wdata)};
  assign mdio_o = shreg[FRAME_BITS-1];
  assign done   = active && fall && (bitcnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      shreg   <= '0;
      bitcnt  <= '0;
      rd_q    <= 1'b0;
      mdio_oe <= 1'b0;
      rx_data <= '0;
      ta_err  <= 1'b0;
    end else if (start && !active) begin
      active  <= 1'b1;
      shreg   <= frame;
      bitcnt  <= '0;
      rd_q    <= is_rd;
      mdio_oe <= 1'b1;
      rx_data <= '0;
      ta_err  <= 1'b0;
    end else if (active) begin
      if (rise && rd_q) begin
        if (bitcnt == TA2_IDX) ta_err <= mdio_i;
        if (bitcnt >= DAT_IDX) rx_data <= {rx_data[14:0], mdio_i};
      end
      if (fall) begin
        if (bitcnt == LAST_IDX) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
          if (rd_q && (bitcnt + 1'b1 == TA1_IDX)) mdio_oe <= 1'b0;
        end
      end
    end
  end

  // R5
  preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
    active && (bitcnt < PRE_IDX) |-> mdio_o && mdio_oe);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    active && rd_q && (bitcnt >= TA1_IDX) |-> !mdio_oe);

  // R5
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    active && $past(active) && !$past(fall) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4,
  parameter int MIN_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEF_DIV);
  localparam logic [DIV_W-1:0] DIV_LO  = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_q;
  mdio_cmd_t        cmd_q;
  logic [15:0]      data_q;
  logic             err_q;
  logic             busy, wr_ok, start_rd, start_wr, start;
  logic             rise, fall, done, ta_err;
  logic [15:0]      rx_data;
  logic [4:0]       go_phy, go_reg;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata[31:16];

  assign wr_ok    = reg_wr && !busy;
  assign start_rd = wr_ok && (reg_addr == ADDR_CMD) && reg_wdata[CMD_RD_BIT];
  assign start_wr = wr_ok && (reg_addr == ADDR_DATA) && !cmd_q.rd;
  assign start    = start_rd || start_wr;
  assign go_phy   = start_rd ? reg_wdata[9:5] : cmd_q.phy;
  assign go_reg   = start_rd ? reg_wdata[4:0] : cmd_q.regad;

  mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst(rst), .run(busy), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(start), .is_rd(start_rd),
    .phy(go_phy), .regad(go_reg), .wdata(reg_wdata[15:0]),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_data(rx_data), .ta_err(ta_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DIV_RST;
      cmd_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && (reg_addr == ADDR_CFG) && (reg_wdata[DIV_W-1:0] >= DIV_LO))
        div_q <= reg_wdata[DIV_W-1:0];
      if (wr_ok && (reg_addr == ADDR_CMD))
        cmd_q <= '{rd: reg_wdata[CMD_RD_BIT], phy: reg_wdata[9:5], regad: reg_wdata[4:0]};
      if (wr_ok && (reg_addr == ADDR_DATA))
        data_q <= reg_wdata[15:0];
      if (start)
        err_q <= 1'b0;
      else if (done && cmd_q.rd)
        err_q <= ta_err;
      if (done && cmd_q.rd)
        data_q <= rx_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CFG: begin
        reg_rdata[BUSY_BIT]  = busy;
        reg_rdata[ERR_BIT]   = err_q;
        reg_rdata[DIV_W-1:0] = div_q;
      end
      ADDR_CMD: begin
        reg_rdata[CMD_RD_BIT] = cmd_q.rd;
        reg_rdata[9:5]        = cmd_q.phy;
        reg_rdata[4:0]        = cmd_q.regad;
      end
      ADDR_DATA: reg_rdata[15:0] = data_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc && !mdio_oe);

  // R2
  div_floor_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && (reg_addr == ADDR_CFG) && (reg_wdata[DIV_W-1:0] < DIV_LO) |=> $stable(div_q));

  // R9
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy && reg_wr && !done |=> $stable(cmd_q) && $stable(data_q) && $stable(div_q));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !err_q);
endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  import mdio_pkg::*;

  localparam int DEF_DIV = 4;
  localparam int MIN_DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_en = 1'b0, phy_val = 1'b1, phy_respond = 1'b1;
  logic [15:0] phy_rdval = '0;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);
  wire         mdio_i = mdio_line;

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  logic [63:0] cap = '0;
  int          bit_idx = 0;
  logic        mon_rd = 1'b0, oe_bad = 1'b0;
  logic [31:0] rv;
  int          cur_div = DEF_DIV;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.DIV_W(8), .DEF_DIV(DEF_DIV), .MIN_DIV(MIN_DIV)) u_mdio_mgmt_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    reg_addr = ADDR_CFG;
    #1;
    cyc = 0;
    while (reg_rdata[BUSY_BIT]) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  // Scoreboard monitor: rebuilds each frame from the line and plays the PHY
  initial begin
    forever begin
      @(posedge mdc);
      cap = {cap[62:0], mdio_line};
      if (bit_idx == 35) mon_rd = (cap[1:0] == 2'b10);
      if (mon_rd && bit_idx >= TA_FIRST && mdio_oe) oe_bad = 1'b1;
      if (mon_rd && phy_respond && bit_idx >= TA_FIRST && bit_idx < 63) begin
        phy_en  = 1'b1;
        phy_val = (bit_idx == TA_FIRST) ? 1'b0 : phy_rdval[62 - bit_idx];
      end
      if (bit_idx == 63) begin
        phy_en = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected frame", cap, 64'h0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(cap == e, "R4/R5 frame content", cap, e);
        end
        if (mon_rd) chk(!oe_bad, "R6 line released in turnaround/data", {63'h0, oe_bad}, 64'h0);
        bit_idx = 0; mon_rd = 1'b0; oe_bad = 1'b0;
      end else begin
        bit_idx++;
      end
    end
  end

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    int cyc;
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d});
    wr_reg(ADDR_CMD, {16'h0, 1'b0, 5'h0, phy, ra});
    wr_reg(ADDR_DATA, {16'h0, d});
    wait_idle(cyc);
    chk(cyc == 128 * cur_div, "R9 busy length on write", 64'(cyc), 64'(128 * cur_div));
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] pv, input bit resp);
    int cyc;
    logic [31:0] d;
    phy_rdval = pv; phy_respond = resp;
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra,
                     (resp ? 2'b10 : 2'b11), (resp ? pv : 16'hFFFF)});
    wr_reg(ADDR_CMD, {16'h0, 1'b1, 5'h0, phy, ra});
    wait_idle(cyc);
    chk(cyc == 128 * cur_div, "R9 busy length on read", 64'(cyc), 64'(128 * cur_div));
    rd_reg(ADDR_DATA, d);
    chk(d[15:0] == (resp ? pv : 16'hFFFF), "R7 read data", 64'(d), 64'(resp ? pv : 16'hFFFF));
    rd_reg(ADDR_CFG, d);
    chk(d[ERR_BIT] == !resp, "R8 read error flag", 64'(d[ERR_BIT]), 64'(!resp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(ADDR_CFG, rv);
    chk(rv == 32'(DEF_DIV), "R1 config after reset", 64'(rv), 64'(DEF_DIV));
    chk(!mdc && !mdio_oe, "R1 mdc/oe low after reset", {62'h0, mdc, mdio_oe}, 64'h0);

    // R2 divider floor and update
    wr_reg(ADDR_CFG, 32'd1);
    rd_reg(ADDR_CFG, rv);
    chk(rv[7:0] == 8'(DEF_DIV), "R2 small divider ignored", 64'(rv[7:0]), 64'(DEF_DIV));
    wr_reg(ADDR_CFG, 32'd3);
    rd_reg(ADDR_CFG, rv);
    chk(rv[7:0] == 8'd3, "R2 divider updated", 64'(rv[7:0]), 64'd3);
    cur_div = 3;

    // R3 MDC high phase length
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'h0F0F});
    wr_reg(ADDR_CMD, {16'h0, 1'b0, 5'h0, 5'h02, 5'h03});
    wr_reg(ADDR_DATA, 32'h0F0F);
    @(posedge mdc);
    hi = 0;
    @(negedge clk);
    while (mdc) begin hi++; @(negedge clk); end
    chk(hi == cur_div, "R3 mdc high phase", 64'(hi), 64'(cur_div));
    hi = 0;
    while (!mdc) begin hi++; @(negedge clk); end
    chk(hi == cur_div, "R3 mdc low phase", 64'(hi), 64'(cur_div));
    wait_idle(cyc);
    chk(!mdc, "R3 mdc idle low", 64'(mdc), 64'h0);

    // R5 write frames, two patterns
    do_write(5'h1F, 5'h00, 16'hA5C3);
    wr_reg(ADDR_CFG, 32'd2);
    cur_div = 2;
    do_write(5'h00, 5'h1F, 16'hFFFF);

    // R4 command readback
    rd_reg(ADDR_CMD, rv);
    chk(rv == 32'h0000_001F, "R4 command fields", 64'(rv), 64'h1F);

    // R4 R6 R7 read with PHY reply
    do_read(5'h11, 5'h0A, 16'h1234, 1'b1);
    rd_reg(ADDR_CMD, rv);
    chk(rv == {16'h0, 1'b1, 5'h0, 5'h11, 5'h0A}, "R4 read command fields", 64'(rv),
        64'({16'h0, 1'b1, 5'h0, 5'h11, 5'h0A}));
    do_read(5'h05, 5'h15, 16'h8001, 1'b1);

    // R8 no reply then cleared by next transaction
    do_read(5'h07, 5'h02, 16'h0000, 1'b0);
    phy_respond = 1'b1;

    // R10 data write while read flag set stores only
    wr_reg(ADDR_DATA, 32'h5A5A);
    rd_reg(ADDR_CFG, rv);
    chk(!rv[BUSY_BIT], "R10 no transaction started", 64'(rv[BUSY_BIT]), 64'h0);
    rd_reg(ADDR_DATA, rv);
    chk(rv[15:0] == 16'h5A5A, "R10 data stored", 64'(rv), 64'h5A5A);

    do_write(5'h03, 5'h04, 16'h1111);
    rd_reg(ADDR_CFG, rv);
    chk(!rv[ERR_BIT], "R8 error cleared by next transaction", 64'(rv[ERR_BIT]), 64'h0);

    // R9 writes during busy ignored
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h2222});
    wr_reg(ADDR_DATA, 32'h2222);
    wr_reg(ADDR_CMD, {16'h0, 1'b1, 5'h0, 5'h1E, 5'h1D});
    wr_reg(ADDR_DATA, 32'hDEAD);
    wr_reg(ADDR_CFG, 32'd9);
    wait_idle(cyc);
    rd_reg(ADDR_CMD, rv);
    chk(rv == {16'h0, 1'b0, 5'h0, 5'h03, 5'h04}, "R9 command held while busy", 64'(rv),
        64'({16'h0, 1'b0, 5'h0, 5'h03, 5'h04}));
    rd_reg(ADDR_DATA, rv);
    chk(rv[15:0] == 16'h2222, "R9 data held while busy", 64'(rv), 64'h2222);
    rd_reg(ADDR_CFG, rv);
    chk(rv[7:0] == 8'd2, "R9 divider held while busy", 64'(rv[7:0]), 64'd2);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && bit_idx == 0, "R5 all frames seen", 64'(exp_q.size()), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule